// File: doc/BRIEF.md
# Write-Only Serial Register Control Port

This block is the slave end of a four-wire serial control link. A host microcontroller writes a small bank of byte-wide configuration registers through it. The block runs on the chip's system clock. The serial clock, select and data lines are brought in through synchronizers, and the serial clock's rising edge is detected inside the block. The host must therefore run the serial clock well below the system clock rate: each serial clock phase must last several system cycles.

A write transaction is framed by the active-low select. The first byte carries a fixed 7-bit device identifier in its upper seven bits and a direction flag in bit 0. The second byte is an index byte: bit 7 turns on automatic index advance, and bits 2:0 name the target register. The data bytes that follow are written to the register bank. Register contents appear in parallel on the outputs. Some registers and fields cannot be written: the status register, the two low bits of the converter control register, and the two unused index slots.

Top module: `cport_top`

## Requirements
- R1: While rst_n is low, and right after it rises, every register output is 00h.
- R2: A bit is taken from the data line on each rising serial clock edge while the select is low, and bytes are assembled most significant bit first.
- R3: The first byte of a transaction must be 20h, which is the identifier 0010000 followed by a 0 direction bit. A first byte with a 1 direction bit (21h), or any other value, makes the block ignore every later byte until the select rises.
- R4: The second byte is the index byte. Bits 2:0 give the register index and bit 7 enables advance. If any of bits 6:3 is 1, the rest of the transaction is ignored.
- R5: With bit 7 of the index byte at 0, every data byte of the transaction goes to the same register, so the last byte wins.
- R6: With bit 7 of the index byte at 1, the index steps by one after each data byte and wraps from 7 to 0.
- R7: Writes have no effect on: index 6 (status_o), bits 1:0 of index 1 (adc_ctl_o), and indices 0 and 7. The writable registers are index 1 adc_ctl_o, 2 dac_ctl_o, 3 att_left_o, 4 att_right_o and 5 port_mode_o.
- R8: If the select rises in the middle of a byte, that partial byte is dropped, and the next transaction starts again with the identifier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | Serial clock from host |
| spi_cs_n_i | input | 1 | Active-low transaction select |
| spi_mosi_i | input | 1 | Serial data from host |
| adc_ctl_o | output | 8 | Register index 1, bits 1:0 read-only |
| dac_ctl_o | output | 8 | Register index 2 |
| att_left_o | output | 8 | Register index 3 |
| att_right_o | output | 8 | Register index 4 |
| port_mode_o | output | 8 | Register index 5 |
| status_o | output | 8 | Register index 6, read-only |

## Verification
The main write path is driven with three kinds of transaction. Single-byte writes show that a byte lands in the register its index names. Bursts with advance on show that the index steps, and a burst that runs through 6, 7 and 0 into 1 shows that the index wraps and that the protected slots are skipped. Bursts with advance off show that the last byte wins in one register. Rejected headers are also sent: a 1 direction bit, a wrong identifier, a nonzero reserved index field and a header-only transaction. Each of these separates a gate that is working from one that lets writes through. Selects that rise mid-byte, both in the header and in the data, separate a clean restart from a bit counter that carries leftover bits into the next transaction.

// File: rtl/cport_pkg.sv
package cport_pkg;

  localparam int DATA_W = 8;
  localparam int IDX_W  = 3;
  localparam int NREG   = 1 << IDX_W;
  localparam int CNT_W  = $clog2(DATA_W);

  localparam int IDX_ADC   = 1;
  localparam int IDX_DAC   = 2;
  localparam int IDX_ATT_L = 3;
  localparam int IDX_ATT_R = 4;
  localparam int IDX_PORT  = 5;
  localparam int IDX_STAT  = 6;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_IDX  = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } txn_state_e;

  // Writable bits of each register slot
  function automatic logic [DATA_W-1:0] wr_mask(input int idx);
    case (idx)
      IDX_ADC:   wr_mask = 8'hFC;
      IDX_DAC,
      IDX_ATT_L,
      IDX_ATT_R,
      IDX_PORT:  wr_mask = 8'hFF;
      default:   wr_mask = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cport_sync.sv
module cport_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cport_shift.sv
module cport_shift
  import cport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o
);

  logic              sclk_d_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [DATA_W-2:0] sh_q, sh_nx;
  logic              vld_q, vld_nx;
  logic [DATA_W-1:0] byte_q, byte_nx;
  logic              rise;

  assign rise = sclk_i & ~sclk_d_q & ~cs_n_i;

  always_comb begin
    cnt_nx  = cnt_q;
    sh_nx   = sh_q;
    vld_nx  = 1'b0;
    byte_nx = byte_q;
    if (cs_n_i) begin
      cnt_nx = '0;
    end else if (rise) begin
      sh_nx  = {sh_q[DATA_W-3:0], mosi_i};
      cnt_nx = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(DATA_W-1)) begin
        vld_nx  = 1'b1;
        byte_nx = {sh_q, mosi_i};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      vld_q    <= 1'b0;
      byte_q   <= '0;
    end else begin
      sclk_d_q <= sclk_i;
      cnt_q    <= cnt_nx;
      sh_q     <= sh_nx;
      vld_q    <= vld_nx;
      if (vld_nx) byte_q <= byte_nx;
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;

  // R8: a high select clears any partial byte
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> (cnt_q == '0) && !vld_q);

  // R2: each sampled edge advances the bit count by one
  a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_i && !sclk_d_q && !cs_n_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

endmodule

// File: rtl/cport_txn.sv
module cport_txn
  import cport_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'b0010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam logic [DATA_W-1:0] HDR_WRITE = {DEV_ID, 1'b0};

  txn_state_e        st_q, st_nx;
  logic [IDX_W-1:0]  ptr_q, ptr_nx;
  logic              inc_q, inc_nx;
  logic              wr_q, wr_nx;
  logic [IDX_W-1:0]  widx_q, widx_nx;
  logic [DATA_W-1:0] wdat_q, wdat_nx;

  always_comb begin
    st_nx   = st_q;
    ptr_nx  = ptr_q;
    inc_nx  = inc_q;
    wr_nx   = 1'b0;
    widx_nx = widx_q;
    wdat_nx = wdat_q;
    if (cs_n_i) begin
      st_nx = ST_HDR;
    end else if (byte_vld_i) begin
      case (st_q)
        ST_HDR:  st_nx = (byte_i == HDR_WRITE) ? ST_IDX : ST_SKIP;
        ST_IDX: begin
          if (byte_i[DATA_W-2:IDX_W] == '0) begin
            ptr_nx = byte_i[IDX_W-1:0];
            inc_nx = byte_i[DATA_W-1];
            st_nx  = ST_DATA;
          end else begin
            st_nx  = ST_SKIP;
          end
        end
        ST_DATA: begin
          wr_nx   = 1'b1;
          widx_nx = ptr_q;
          wdat_nx = byte_i;
          if (inc_q) ptr_nx = ptr_q + 1'b1;
        end
        default: st_nx = ST_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      ptr_q  <= '0;
      inc_q  <= 1'b0;
      wr_q   <= 1'b0;
      widx_q <= '0;
      wdat_q <= '0;
    end else begin
      st_q   <= st_nx;
      ptr_q  <= ptr_nx;
      inc_q  <= inc_nx;
      wr_q   <= wr_nx;
      widx_q <= widx_nx;
      wdat_q <= wdat_nx;
    end
  end

  assign wr_en_o   = wr_q;
  assign wr_idx_o  = widx_q;
  assign wr_data_o = wdat_q;

  // R3: a rejected header sends the transaction to the skip state
  a_r3_hdr_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && byte_vld_i && st_q == ST_HDR && byte_i != HDR_WRITE) |=> st_q == ST_SKIP);

  // R6: with advance on, the index steps after a data byte
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && byte_vld_i && st_q == ST_DATA && inc_q) |=> ptr_q == IDX_W'($past(ptr_q) + 1'b1));

  // R5: with advance off, the index holds
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && byte_vld_i && st_q == ST_DATA && !inc_q) |=> $stable(ptr_q));

  // R4: no write is issued outside the data phase
  a_r4_no_early_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_DATA) |=> !wr_q);

endmodule

// File: rtl/cport_regs.sv
module cport_regs
  import cport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] adc_ctl_o,
  output logic [DATA_W-1:0] dac_ctl_o,
  output logic [DATA_W-1:0] att_left_o,
  output logic [DATA_W-1:0] att_right_o,
  output logic [DATA_W-1:0] port_mode_o,
  output logic [DATA_W-1:0] status_o
);

  logic [DATA_W-1:0] reg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = wr_mask(g);
    logic              hit;
    logic [DATA_W-1:0] nx;

    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_comb begin
      nx = reg_q[g];
      if (hit) nx = (reg_q[g] & ~MASK) | (wr_data_i & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[g] <= '0;
      else if (hit) reg_q[g] <= nx;
    end
  end

  assign adc_ctl_o   = reg_q[IDX_ADC];
  assign dac_ctl_o   = reg_q[IDX_DAC];
  assign att_left_o  = reg_q[IDX_ATT_L];
  assign att_right_o = reg_q[IDX_ATT_R];
  assign port_mode_o = reg_q[IDX_PORT];
  assign status_o    = reg_q[IDX_STAT];

  // R7: protected status register never moves
  a_r7_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(reg_q[IDX_STAT]));

  // R7: protected low bits of the converter control register never move
  a_r7_adc_low_ro: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(reg_q[IDX_ADC][1:0]));

  // R5: a write to another slot leaves the attenuator left register alone
  a_r5_other_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i != IDX_W'(IDX_ATT_L)) |=> $stable(reg_q[IDX_ATT_L]));

endmodule

// File: rtl/cport_top.sv
module cport_top
  import cport_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ID      = 7'b0010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_n_i,
  input  logic              spi_mosi_i,
  output logic [DATA_W-1:0] adc_ctl_o,
  output logic [DATA_W-1:0] dac_ctl_o,
  output logic [DATA_W-1:0] att_left_o,
  output logic [DATA_W-1:0] att_right_o,
  output logic [DATA_W-1:0] port_mode_o,
  output logic [DATA_W-1:0] status_o
);

  logic [2:0]        pins_s;
  logic              byte_vld;
  logic [DATA_W-1:0] byte_val;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  cport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({spi_sclk_i, spi_cs_n_i, spi_mosi_i}),
    .q_o   (pins_s)
  );

  cport_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_i     (pins_s[2]),
    .cs_n_i     (pins_s[1]),
    .mosi_i     (pins_s[0]),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_val)
  );

  cport_txn #(.DEV_ID(DEV_ID)) u_txn (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (pins_s[1]),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_val),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  cport_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data),
    .adc_ctl_o   (adc_ctl_o),
    .dac_ctl_o   (dac_ctl_o),
    .att_left_o  (att_left_o),
    .att_right_o (att_right_o),
    .port_mode_o (port_mode_o),
    .status_o    (status_o)
  );

endmodule

// File: tb/cport_top_tb_top.sv
`timescale 1ns/1ps
module cport_top_tb_top;

  localparam int HP = 4;  // serial clock half period in system clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic [7:0] adc, dac, attl, attr, pmode, stat;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cport_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk_i(sclk), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi),
    .adc_ctl_o(adc), .dac_ctl_o(dac), .att_left_o(attl),
    .att_right_o(attr), .port_mode_o(pmode), .status_o(stat)
  );

  // {req, hdr, idx, d0, d1, d2, d3, nbytes, exp adc,dac,attl,attr,port,stat}
  localparam int NV = 10;
  localparam logic [111:0] VEC [NV] = '{
    {8'd2, 8'h20, 8'h03, 32'hAA000000, 8'd1, 48'h0000AA000000}, // R2 single write att left
    {8'd6, 8'h20, 8'h84, 32'h11223300, 8'd3, 48'h0000AA112200}, // R6 advance, status untouched
    {8'd5, 8'h20, 8'h02, 32'h5A5B5C00, 8'd3, 48'h005CAA112200}, // R5 no advance, last wins
    {8'd3, 8'h21, 8'h03, 32'hFF000000, 8'd1, 48'h005CAA112200}, // R3 read direction ignored
    {8'd3, 8'h22, 8'h03, 32'hFF000000, 8'd1, 48'h005CAA112200}, // R3 wrong identifier
    {8'd7, 8'h20, 8'h01, 32'hFF000000, 8'd1, 48'hFC5CAA112200}, // R7 adc low bits held
    {8'd6, 8'h20, 8'h86, 32'h01020337, 8'd4, 48'h345CAA112200}, // R6 wrap 6,7,0 into 1
    {8'd4, 8'h20, 8'h0B, 32'h77000000, 8'd1, 48'h345CAA112200}, // R4 reserved index bits
    {8'd7, 8'h20, 8'h85, 32'h99660000, 8'd2, 48'h345CAA119900}, // R7 status write dropped
    {8'd4, 8'h20, 8'h03, 32'h00000000, 8'd0, 48'h345CAA119900}  // R4 header only
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b);
    mosi = b;
    wait_clk(HP);
    sclk = 1'b1;
    wait_clk(HP);
    sclk = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) spi_bit(b[i]);
  endtask

  task automatic spi_begin();
    cs_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic spi_end();
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] outs();
    return {adc, dac, attl, attr, pmode, stat};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    chk("R1 during reset", outs(), 48'h0);
    rst_n = 1'b1;
    wait_clk(3);
    chk("R1 after reset", outs(), 48'h0);

    for (int v = 0; v < NV; v++) begin
      logic [111:0] e;
      e = VEC[v];
      spi_begin();
      spi_byte(e[103:96]);
      spi_byte(e[95:88]);
      for (int k = 0; k < int'(e[55:48]); k++) spi_byte(e[87-8*k -: 8]);
      spi_end();
      chk($sformatf("R%0d vector %0d", e[111:104], v), outs(), e[47:0]);
    end

    // R8: abort inside the header, then a fresh write must land
    spi_begin();
    spi_byte(8'h20);
    for (int i = 0; i < 4; i++) spi_bit(1'b1);
    spi_end();
    spi_begin();
    spi_byte(8'h20);
    spi_byte(8'h03);
    spi_byte(8'hC3);
    spi_end();
    chk("R8 restart after header abort", outs(), 48'h345CC3119900);

    // R8: abort inside a data byte leaves the target unchanged
    spi_begin();
    spi_byte(8'h20);
    spi_byte(8'h04);
    for (int i = 0; i < 5; i++) spi_bit(1'b1);
    spi_end();
    chk("R8 partial data byte dropped", outs(), 48'h345CC3119900);

    // R2: alternating bit pattern, MSB first, into port mode
    spi_begin();
    spi_byte(8'h20);
    spi_byte(8'h05);
    spi_byte(8'hA5);
    spi_end();
    chk("R2 msb first A5", outs(), 48'h345CC311A500);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    wait_clk(2);
    chk("R1 reset clears", outs(), 48'h0);
    rst_n = 1'b1;
    wait_clk(3);
    chk("R1 after second reset", outs(), 48'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule